// File: doc/BRIEF.md
# Serial Control Register Target for a Stereo Tone and Volume Processor

This block is a write-only two-wire serial target. It receives control bytes for a stereo audio processor and keeps them in six function registers. A transfer opens with START and the 8-bit address byte. The next byte is a subaddress: its low nibble picks the register to write, and one of its bits turns on stepping to the following register for each later byte. Every byte after the subaddress loads the register currently selected.

Both bus lines are brought into the system clock domain through a two-stage synchroniser before any edge is detected. The block signals acknowledge by asserting an active-high pull-down request, which drives the open-drain data line low. Three small decoders turn the stored bytes into gain numbers for downstream logic. The volume byte gives a signed value in dB. The tone byte gives the treble boost and the bass boost in dB.

Top module: `audio_ctl_target`

## Requirements
- R1: Only the address byte 0x88 (target address 0x44 followed by a write bit of 0) is acknowledged. Any other address byte, 0x89 included, gets no acknowledge, and no register changes until the next START.
- R2: During the ninth clock of every accepted byte, `sda_pull_low` is 1. Accepted bytes are the matching address byte, the subaddress byte and each data byte. It returns to 0 after the falling edge of that ninth clock.
- R3: Subaddress bits [3:0] select the register. The values are 0 for volume, 1 for tone (treble/bass), 2 for input and mute, 3 for standby, 4 for bass level control 1 and 5 for bass level control 2.
- R4: When subaddress bit 4 is 1, each data byte after the first goes to the next register index. When bit 4 is 0, every data byte rewrites the same register.
- R5: Subaddress bits [7:5] have no effect on the register selected or on the stepping behaviour.
- R6: A subaddress of 6 to 15 is acknowledged but writes no register. When stepping runs past index 5, later bytes are acknowledged and discarded. The index does not wrap to 0.
- R7: A register changes only after all 8 bits of its data byte have arrived. A START or STOP in the middle of a byte drops that byte, and every register keeps its value.
- R8: `vol_db` equals boost + fine + coarse. Volume bits [1:0] give the boost: 00 gives +6, 01 gives +4, 10 gives +2 and 11 gives 0 dB. Bits [4:2] give the fine part, 0 to -7 dB in 1 dB steps. Bits [7:5] give the coarse part, 0 to -56 dB in 8 dB steps. The output spans +6 down to -63 dB.
- R9: `treble_db` follows tone bits [1:0], with 00/01/10/11 giving 12/8/4/0 dB. `bass_db` follows tone bits [4:2], with 000 through 111 giving 14 down to 0 dB in 2 dB steps.
- R10: Reset clears all six registers to 0x00 and sets `sda_pull_low` to 0. As a result, `vol_db` is +6, `treble_db` is 12 and `bass_db` is 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as sensed |
| sda_in | input | 1 | Serial data line as sensed |
| sda_pull_low | output | 1 | Request to drive the data line low (acknowledge) |
| vol_cfg | output | 8 | Volume register (index 0) |
| tone_cfg | output | 8 | Treble/bass register (index 1) |
| input_cfg | output | 8 | Input select and mute register (index 2) |
| standby_cfg | output | 8 | Standby and miscellaneous register (index 3) |
| alc1_cfg | output | 8 | Bass level control register 1 (index 4) |
| alc2_cfg | output | 8 | Bass level control register 2 (index 5) |
| vol_db | output | 8 | Decoded volume in dB, two's complement |
| treble_db | output | 4 | Decoded treble boost in dB |
| bass_db | output | 4 | Decoded bass boost in dB |

## Verification
The bench writes the same registers several ways and compares all six registers and the decoded gains after each transfer:
- Single-register writes with and without the stepping bit show whether the index advances or holds.
- Subaddresses with the upper bits set show that those bits are ignored.
- Indices of 6 and above, and stepping off the end of the bank, show that nothing wraps or spills into another register.
- Foreign addresses, including the read variant of the target's own address, separate an address match from a simple bit count.
- Transfers cut short by STOP and by a repeated START show whether a partial byte can leak into a register.
- Volume bytes that exercise each field on its own, plus mixed values, show whether boost, fine and coarse are summed with the right weights.

// File: rtl/audio_ctl_pkg.sv
package audio_ctl_pkg;

    localparam int BYTE_W    = 8;
    localparam int REG_COUNT = 6;
    localparam int IDX_W     = 4;
    localparam int AUTO_BIT  = 4;
    localparam logic [BYTE_W-1:0] TARGET_ADDR = 8'h88;

    typedef enum logic [1:0] {
        LINK_IDLE,
        LINK_RECV,
        LINK_ACK,
        LINK_SKIP
    } link_state_t;

    typedef struct packed {
        logic              valid;
        logic              first;
        logic [BYTE_W-1:0] data;
    } rx_byte_t;

    typedef struct packed {
        logic [2:0] coarse;
        logic [2:0] fine;
        logic [1:0] boost;
    } vol_fields_t;

    typedef struct packed {
        logic [2:0] spare;
        logic [2:0] bass;
        logic [1:0] treble;
    } tone_fields_t;

    function automatic logic signed [7:0] vol_to_db(input logic [7:0] raw);
        vol_fields_t f;
        int          g;
        f = raw;
        g = 6 - 2 * int'(f.boost) - int'(f.fine) - 8 * int'(f.coarse);
        return g[7:0];
    endfunction

    function automatic logic [3:0] treble_to_db(input logic [1:0] t);
        int g;
        g = 12 - 4 * int'(t);
        return g[3:0];
    endfunction

    function automatic logic [3:0] bass_to_db(input logic [2:0] b);
        int g;
        g = 14 - 2 * int'(b);
        return g[3:0];
    endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_bit
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw_in;
    logic [LINES-1:0] now_v;
    logic [LINES-1:0] prev_v;

    assign raw_in = {sda_in, scl_in};

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [STAGES:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) begin
                pipe <= '1;
            end else begin
                pipe <= {pipe[STAGES-1:0], raw_in[i]};
            end
        end
        assign now_v[i]  = pipe[STAGES-1];
        assign prev_v[i] = pipe[STAGES];
    end

    assign scl_rise  = now_v[0] & ~prev_v[0];
    assign scl_fall  = ~now_v[0] & prev_v[0];
    assign start_det = now_v[0] & prev_v[0] & prev_v[1] & ~now_v[1];
    assign stop_det  = now_v[0] & prev_v[0] & ~prev_v[1] & now_v[1];
    assign sda_bit   = now_v[1];

endmodule

// File: rtl/link_target.sv
module link_target
    import audio_ctl_pkg::*;
#(
    parameter logic [BYTE_W-1:0] ADDR = TARGET_ADDR
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_rise,
    input  logic     scl_fall,
    input  logic     start_det,
    input  logic     stop_det,
    input  logic     sda_bit,
    output rx_byte_t rx,
    output logic     sda_pull
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    link_state_t       state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              addr_phase;
    logic              first_pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= LINK_IDLE;
            bit_cnt       <= '0;
            shreg         <= '0;
            addr_phase    <= 1'b0;
            first_pending <= 1'b0;
            sda_pull      <= 1'b0;
            rx            <= '0;
        end else begin
            rx.valid <= 1'b0;
            if (start_det) begin
                state         <= LINK_RECV;
                bit_cnt       <= '0;
                addr_phase    <= 1'b1;
                first_pending <= 1'b1;
                sda_pull      <= 1'b0;
            end else if (stop_det) begin
                state    <= LINK_IDLE;
                sda_pull <= 1'b0;
            end else begin
                unique case (state)
                    LINK_RECV: begin
                        if (scl_rise && bit_cnt < FULL) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_bit};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == FULL) begin
                            if (addr_phase) begin
                                if (shreg == ADDR) begin
                                    state    <= LINK_ACK;
                                    sda_pull <= 1'b1;
                                end else begin
                                    state <= LINK_SKIP;
                                end
                            end else begin
                                rx            <= '{valid: 1'b1, first: first_pending, data: shreg};
                                first_pending <= 1'b0;
                                state         <= LINK_ACK;
                                sda_pull      <= 1'b1;
                            end
                        end
                    end
                    LINK_ACK: begin
                        if (scl_fall) begin
                            sda_pull   <= 1'b0;
                            state      <= LINK_RECV;
                            bit_cnt    <= '0;
                            addr_phase <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2
    pull_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (sda_pull != $past(sda_pull)) |-> $past(scl_fall || start_det || stop_det));

    // R1
    skip_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (state == LINK_SKIP && !start_det) |=> !rx.valid && !sda_pull);

endmodule

// File: rtl/reg_bank.sv
module reg_bank
    import audio_ctl_pkg::*;
#(
    parameter int NREG = REG_COUNT
) (
    input  logic                         clk,
    input  logic                         rst,
    input  rx_byte_t                     rx,
    output logic [NREG-1:0][BYTE_W-1:0]  regs
);
    localparam logic [IDX_W-1:0] LAST_PLUS = IDX_W'(NREG);

    logic [IDX_W-1:0] ptr;
    logic             auto_inc;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr      <= '0;
            auto_inc <= 1'b0;
        end else if (rx.valid) begin
            if (rx.first) begin
                ptr      <= rx.data[IDX_W-1:0];
                auto_inc <= rx.data[AUTO_BIT];
            end else if (auto_inc && ptr < LAST_PLUS) begin
                ptr <= ptr + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (rx.valid && !rx.first && ptr == IDX_W'(g)) begin
                regs[g] <= rx.data;
            end
        end
    end

    // R7
    regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rx.valid |=> $stable(regs));

    // R6
    past_end_chk: assert property (@(posedge clk) disable iff (rst)
        (rx.valid && !rx.first && ptr >= LAST_PLUS) |=> $stable(regs) && $stable(ptr));

endmodule

// File: rtl/level_decode.sv
module level_decode
    import audio_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [7:0]         vol_raw,
    input  logic [7:0]         tone_raw,
    output logic signed [7:0]  vol_db,
    output logic [3:0]         treble_db,
    output logic [3:0]         bass_db
);
    tone_fields_t tone_f;

    always_comb begin
        tone_f    = tone_raw;
        vol_db    = vol_to_db(vol_raw);
        treble_db = treble_to_db(tone_f.treble);
        bass_db   = bass_to_db(tone_f.bass);
    end

    // R8
    vol_range_chk: assert property (@(posedge clk) disable iff (rst)
        vol_db <= 8'sd6 && vol_db >= -8'sd63);

    // R9
    tone_range_chk: assert property (@(posedge clk) disable iff (rst)
        treble_db <= 4'd12 && bass_db <= 4'd14 && !treble_db[0] && !bass_db[0]);

endmodule

// File: rtl/audio_ctl_target.sv
module audio_ctl_target
    import audio_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull_low,
    output logic [7:0]        vol_cfg,
    output logic [7:0]        tone_cfg,
    output logic [7:0]        input_cfg,
    output logic [7:0]        standby_cfg,
    output logic [7:0]        alc1_cfg,
    output logic [7:0]        alc2_cfg,
    output logic signed [7:0] vol_db,
    output logic [3:0]        treble_db,
    output logic [3:0]        bass_db
);
    logic     scl_rise, scl_fall, start_det, stop_det, sda_bit;
    rx_byte_t rx;
    logic [REG_COUNT-1:0][BYTE_W-1:0] regs;

    line_sync #(.STAGES(2)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_bit   (sda_bit)
    );

    link_target #(.ADDR(TARGET_ADDR)) u_link (
        .clk       (clk),
        .rst       (rst),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_bit   (sda_bit),
        .rx        (rx),
        .sda_pull  (sda_pull_low)
    );

    reg_bank #(.NREG(REG_COUNT)) u_bank (
        .clk  (clk),
        .rst  (rst),
        .rx   (rx),
        .regs (regs)
    );

    level_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .vol_raw   (regs[0]),
        .tone_raw  (regs[1]),
        .vol_db    (vol_db),
        .treble_db (treble_db),
        .bass_db   (bass_db)
    );

    assign vol_cfg     = regs[0];
    assign tone_cfg    = regs[1];
    assign input_cfg   = regs[2];
    assign standby_cfg = regs[3];
    assign alc1_cfg    = regs[4];
    assign alc2_cfg    = regs[5];

endmodule

// File: tb/audio_ctl_target_test.sv
module audio_ctl_target_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_line;
    logic sda_pull_low;
    logic [7:0] vol_cfg, tone_cfg, input_cfg, standby_cfg, alc1_cfg, alc2_cfg;
    logic signed [7:0] vol_db;
    logic [3:0] treble_db, bass_db;

    always #2 clk = ~clk;

    assign sda_line = sda_drv & ~sda_pull_low;

    audio_ctl_target uut (
        .clk          (clk),
        .rst          (rst),
        .scl_in       (scl_drv),
        .sda_in       (sda_line),
        .sda_pull_low (sda_pull_low),
        .vol_cfg      (vol_cfg),
        .tone_cfg     (tone_cfg),
        .input_cfg    (input_cfg),
        .standby_cfg  (standby_cfg),
        .alc1_cfg     (alc1_cfg),
        .alc2_cfg     (alc2_cfg),
        .vol_db       (vol_db),
        .treble_db    (treble_db),
        .bass_db      (bass_db)
    );

    typedef struct {
        string       tag;
        logic [47:0] regs;
    } sb_item_t;

    sb_item_t   sbq[$];
    int         checks = 0;
    int         errors = 0;
    logic [7:0] exp_regs [6];
    logic [7:0] tx_data [8];
    logic       ack;

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    function automatic logic [7:0] get_reg(input int i);
        case (i)
            0: return vol_cfg;
            1: return tone_cfg;
            2: return input_cfg;
            3: return standby_cfg;
            4: return alc1_cfg;
            default: return alc2_cfg;
        endcase
    endfunction

    function automatic int exp_vol(input logic [7:0] b);
        return 6 - 2 * int'(b[1:0]) - int'(b[4:2]) - 8 * int'(b[7:5]);
    endfunction

    task automatic wq();
        repeat (8) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wq();
        scl_drv = 1'b1; wq();
        sda_drv = 1'b0; wq();
        scl_drv = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wq();
        scl_drv = 1'b1; wq();
        sda_drv = 1'b1; wq(); wq();
    endtask

    task automatic send_bit(input logic b);
        sda_drv = b; wq();
        scl_drv = 1'b1; wq(); wq();
        scl_drv = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic got_ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_drv = 1'b1; wq();
        scl_drv = 1'b1; wq();
        got_ack = ~sda_line; wq();
        scl_drv = 1'b0; wq();
    endtask

    task automatic model_apply(input logic [7:0] sub, input int n);
        int   ptr;
        logic inc;
        ptr = int'(sub[3:0]);
        inc = sub[4];
        for (int i = 0; i < n; i++) begin
            if (ptr < 6) exp_regs[ptr] = tx_data[i];
            if (inc && ptr < 6) ptr++;
        end
    endtask

    task automatic push(input string tag);
        sb_item_t it;
        it.tag = tag;
        for (int i = 0; i < 6; i++) it.regs[8*i +: 8] = exp_regs[i];
        sbq.push_back(it);
        wait (sbq.size() == 0);
    endtask

    task automatic xfer(input logic [7:0] addr, input logic [7:0] sub, input int n, input string tag);
        logic hit;
        hit = (addr == 8'h88);
        bus_start();
        send_byte(addr, ack);
        check({tag, " R1 address ack"}, int'(ack), int'(hit));
        send_byte(sub, ack);
        check({tag, " R2 subaddress ack"}, int'(ack), int'(hit));
        for (int i = 0; i < n; i++) begin
            send_byte(tx_data[i], ack);
            check({tag, " R2 data ack"}, int'(ack), int'(hit));
        end
        bus_stop();
        if (hit) model_apply(sub, n);
        push(tag);
    endtask

    // scoreboard monitor
    initial begin
        sb_item_t it;
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                it = sbq[0];
                for (int i = 0; i < 6; i++)
                    check({it.tag, $sformatf(" reg%0d", i)}, int'(get_reg(i)), int'(it.regs[8*i +: 8]));
                check({it.tag, " R8 vol_db"}, int'(vol_db), exp_vol(it.regs[7:0]));
                check({it.tag, " R9 treble_db"}, int'(treble_db), 12 - 4 * int'(it.regs[9:8]));
                check({it.tag, " R9 bass_db"}, int'(bass_db), 14 - 2 * int'(it.regs[12:10]));
                check({it.tag, " R2 released"}, int'(sda_pull_low), 0);
                void'(sbq.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual 0 expected 1 (run completed)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 6; i++) exp_regs[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        wq();

        // R10 reset state
        for (int i = 0; i < 6; i++) check($sformatf("R10 reg%0d", i), int'(get_reg(i)), 0);
        check("R10 vol_db", int'(vol_db), 6);
        check("R10 treble_db", int'(treble_db), 12);
        check("R10 bass_db", int'(bass_db), 14);
        check("R10 sda_pull_low", int'(sda_pull_low), 0);

        tx_data[0] = 8'hFF;
        xfer(8'h88, 8'h00, 1, "R3 volume write");

        tx_data[0] = 8'h55;
        xfer(8'h8A, 8'h01, 1, "R1 foreign address");
        xfer(8'h89, 8'h10, 1, "R1 read address");

        tx_data[0] = 8'h11; tx_data[1] = 8'h1B; tx_data[2] = 8'h22; tx_data[3] = 8'h33;
        tx_data[4] = 8'h44; tx_data[5] = 8'h55; tx_data[6] = 8'hAA;
        xfer(8'h88, 8'h10, 7, "R4 R6 auto-increment to end");

        tx_data[0] = 8'h01; tx_data[1] = 8'h02; tx_data[2] = 8'h03;
        xfer(8'h88, 8'h02, 3, "R4 no increment");

        tx_data[0] = 8'h5A; tx_data[1] = 8'h6B;
        xfer(8'h88, 8'hE3, 2, "R5 upper bits no increment");

        tx_data[0] = 8'h70; tx_data[1] = 8'h71; tx_data[2] = 8'h72;
        xfer(8'h88, 8'hF4, 3, "R5 upper bits with increment");

        tx_data[0] = 8'h99; tx_data[1] = 8'h98;
        xfer(8'h88, 8'h07, 2, "R6 index 7");
        tx_data[0] = 8'h12;
        xfer(8'h88, 8'h1F, 1, "R6 index 15 increment");

        // R7 STOP in the middle of a data byte
        bus_start();
        send_byte(8'h88, ack);
        check("R7 abort address ack", int'(ack), 1);
        send_byte(8'h00, ack);
        check("R7 abort subaddress ack", int'(ack), 1);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_stop();
        push("R7 stop mid-byte");

        // R7 repeated START in the middle of a data byte
        bus_start();
        send_byte(8'h88, ack);
        send_byte(8'h00, ack);
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        bus_start();
        send_byte(8'h88, ack);
        check("R7 restart address ack", int'(ack), 1);
        send_byte(8'h00, ack);
        tx_data[0] = 8'h25;
        send_byte(tx_data[0], ack);
        check("R7 restart data ack", int'(ack), 1);
        bus_stop();
        model_apply(8'h00, 1);
        push("R7 start mid-byte then write");

        tx_data[0] = 8'h03;
        xfer(8'h88, 8'h00, 1, "R8 no boost");
        tx_data[0] = 8'h1C;
        xfer(8'h88, 8'h00, 1, "R8 fine only");
        tx_data[0] = 8'hE0;
        xfer(8'h88, 8'h00, 1, "R8 coarse with boost");

        tx_data[0] = 8'h02;
        xfer(8'h88, 8'h01, 1, "R9 treble 4");
        tx_data[0] = 8'h1D;
        xfer(8'h88, 8'h01, 1, "R9 bass 0 treble 8");

        repeat (20) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule